// File: doc/BRIEF.md
# Flash Write Control Register

This block is an eight-bit special-function control register for an 8051-class microcontroller core. It decides where external-memory move writes land. With the program-write bit clear they go to data RAM; with it set, a move from the accumulator through the data pointer programs one byte of flash at the data-pointer address. The register also arms a mass erase, holds a one-way security lock, and reports whether the preboot sequence is running.

Software writes the register through the core's SFR write port. The flash controller sends back a one-cycle pulse after each programmed byte and another after each finished mass erase. Each pulse clears the matching control bit, so software has to re-arm before every operation. The program-write bit cannot be changed while interrupts are globally enabled. Once set, the lock stays set until chip reset. While it is set, it blocks external flash-read requests.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset, the steering, arm and lock outputs are 0, and the readback shows 0 in bits 0 to 6.
- R2: With the interrupt-enable input low, an SFR write loads data bit 0 into the program-write bit (readback bit 0, output `prog_wr_steer`) at the write's clock edge.
- R3: With the interrupt-enable input high, an SFR write leaves the program-write bit unchanged.
- R4: A byte-written pulse clears the program-write bit at the clock edge where it is sampled. An SFR write at that same edge loses to the clear.
- R5: An SFR write loads data bit 1 into the mass-erase arm (readback bit 1, output `erase_arm`) whatever the interrupt-enable state.
- R6: An erase-done pulse clears the mass-erase arm at the clock edge where it is sampled. An SFR write at that same edge loses to the clear.
- R7: An SFR write with data bit 6 set sets the security lock (readback bit 6, output `sec_lock`). A write with bit 6 clear leaves the lock as it is. Only reset clears it.
- R8: Readback bit 7 follows the `preboot_active` input combinationally and ignores writes.
- R9: Readback bits 2 to 5 always read 0, whatever is written.
- R10: `ext_rd_grant` equals `ext_rd_req` while the lock is clear and is 0 while the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| sfr_we | input | 1 | SFR write strobe for this register |
| sfr_wdata | input | 8 | SFR write data |
| irq_glob_en | input | 1 | Global interrupt-enable state of the core |
| byte_done | input | 1 | One-cycle pulse: a flash byte was programmed |
| erase_done | input | 1 | One-cycle pulse: a mass erase finished |
| preboot_active | input | 1 | Preboot sequence is running |
| ext_rd_req | input | 1 | External flash-read request |
| prog_wr_steer | output | 1 | Steers move writes to program flash |
| erase_arm | output | 1 | Mass erase armed |
| sec_lock | output | 1 | Security lock |
| ext_rd_grant | output | 1 | External read request passed through the lock |
| sfr_rdata | output | 8 | Register readback |

## Verification
The bench writes all 256 data values under both interrupt-enable states, resetting between writes. A design that ignored the interrupt gate, let a reserved bit through, or mixed up bit positions would show a wrong readback for some value. Directed cases put a software write and a completion pulse on the same clock edge; a design with the wrong priority would leave a bit armed after the operation finished. The lock is written with 0 after being set, and checked against the read grant, so a lock that a write could clear, or a grant that ignored the lock, is caught.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int REG_W     = 8;
  localparam int PWE_POS   = 0;
  localparam int ERASE_POS = 1;
  localparam int LOCK_POS  = 6;
  localparam int BOOT_POS  = 7;
endpackage

// File: rtl/fwc_pwe_bit.sv
module fwc_pwe_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic irq_glob_en,
  input  logic byte_done,
  output logic pwe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pwe_q <= 1'b0;
    else if (byte_done)             pwe_q <= 1'b0;
    else if (wr_en && !irq_glob_en) pwe_q <= wr_val;
  end

  // R4
  pwe_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !pwe_q);

  // R3
  pwe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_glob_en && !byte_done) |=> $stable(pwe_q));
endmodule

// File: rtl/fwc_erase_bit.sv
module fwc_erase_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic erase_done,
  output logic arm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arm_q <= 1'b0;
    else if (erase_done) arm_q <= 1'b0;
    else if (wr_en)      arm_q <= wr_val;
  end

  // R6
  arm_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !arm_q);
endmodule

// File: rtl/fwc_lock_bit.sv
module fwc_lock_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lock_q <= 1'b0;
    else if (wr_en && wr_val) lock_q <= 1'b1;
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import fwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfr_we,
  input  logic [REG_W-1:0] sfr_wdata,
  input  logic             irq_glob_en,
  input  logic             byte_done,
  input  logic             erase_done,
  input  logic             preboot_active,
  input  logic             ext_rd_req,
  output logic             prog_wr_steer,
  output logic             erase_arm,
  output logic             sec_lock,
  output logic             ext_rd_grant,
  output logic [REG_W-1:0] sfr_rdata
);
  logic pwe_q, arm_q, lock_q;
  logic unused_wbits;

  fwc_pwe_bit u_pwe (
    .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .wr_val(sfr_wdata[PWE_POS]),
    .irq_glob_en(irq_glob_en), .byte_done(byte_done), .pwe_q(pwe_q));

  fwc_erase_bit u_erase (
    .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .wr_val(sfr_wdata[ERASE_POS]),
    .erase_done(erase_done), .arm_q(arm_q));

  fwc_lock_bit u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .wr_val(sfr_wdata[LOCK_POS]),
    .lock_q(lock_q));

  // Bits of the write data that no field stores (reserved and status).
  always_comb begin
    unused_wbits = 1'b0;
    for (int i = 0; i < REG_W; i++)
      if (i != PWE_POS && i != ERASE_POS && i != LOCK_POS)
        unused_wbits = unused_wbits ^ sfr_wdata[i];
  end

  always_comb begin
    sfr_rdata            = '0;
    sfr_rdata[PWE_POS]   = pwe_q;
    sfr_rdata[ERASE_POS] = arm_q;
    sfr_rdata[LOCK_POS]  = lock_q;
    sfr_rdata[BOOT_POS]  = preboot_active;
  end

  assign prog_wr_steer = pwe_q;
  assign erase_arm     = arm_q;
  assign sec_lock      = lock_q;
  assign ext_rd_grant  = ext_rd_req & ~lock_q;

  // R10
  lock_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lock |-> !ext_rd_grant);

  // R2
  pwe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && !irq_glob_en && !byte_done) |=> (prog_wr_steer == $past(sfr_wdata[PWE_POS])));
endmodule

// File: tb/flash_wr_ctrl_bench.sv
module flash_wr_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic irq_glob_en = 1'b0;
  logic byte_done = 1'b0;
  logic erase_done = 1'b0;
  logic preboot_active = 1'b0;
  logic ext_rd_req = 1'b0;
  logic prog_wr_steer, erase_arm, sec_lock, ext_rd_grant;
  logic [7:0] sfr_rdata;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_wr_ctrl u_flash_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .irq_glob_en(irq_glob_en), .byte_done(byte_done), .erase_done(erase_done),
    .preboot_active(preboot_active), .ext_rd_req(ext_rd_req),
    .prog_wr_steer(prog_wr_steer), .erase_arm(erase_arm), .sec_lock(sec_lock),
    .ext_rd_grant(ext_rd_grant), .sfr_rdata(sfr_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // One clock with the given stimulus, released at the next falling edge.
  task automatic step(input logic we, input logic [7:0] d, input logic bd, input logic ed);
    @(negedge clk);
    sfr_we = we; sfr_wdata = d; byte_done = bd; erase_done = ed;
    @(negedge clk);
    sfr_we = 1'b0; byte_done = 1'b0; erase_done = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    do_reset(); #1;
    // R1
    chk("R1", sfr_rdata, 8'h00);
    chk("R1", {5'd0, prog_wr_steer, erase_arm, sec_lock}, 8'h00);

    // R2 R3 R5 R7 R8 R9 R10: full sweep of data under both gate states
    for (int ie = 0; ie < 2; ie++) begin
      for (int v = 0; v < 256; v++) begin
        do_reset();
        irq_glob_en = ie[0];
        preboot_active = v[3];
        ext_rd_req = 1'b1;
        step(1'b1, v[7:0], 1'b0, 1'b0);
        exp = {v[3], v[6], 4'b0000, v[1], (ie == 0) ? v[0] : 1'b0};
        chk("R2/R3/R5/R7/R8/R9 readback", sfr_rdata, exp);
        chk("R2 steer", {7'd0, prog_wr_steer}, {7'd0, exp[0]});
        chk("R10 grant", {7'd0, ext_rd_grant}, {7'd0, ~v[6]});
      end
    end
    irq_glob_en = 1'b0; preboot_active = 1'b0;

    // R4: byte pulse clears program-write bit
    do_reset();
    step(1'b1, 8'h01, 1'b0, 1'b0);
    chk("R4 set", {7'd0, prog_wr_steer}, 8'h01);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R4 clear", {7'd0, prog_wr_steer}, 8'h00);
    step(1'b1, 8'h01, 1'b0, 1'b0);
    step(1'b1, 8'h01, 1'b1, 1'b0);
    chk("R4 write loses", {7'd0, prog_wr_steer}, 8'h00);

    // R3: gate holds a set bit against a clearing write
    step(1'b1, 8'h01, 1'b0, 1'b0);
    irq_glob_en = 1'b1;
    step(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R3 hold", {7'd0, prog_wr_steer}, 8'h01);
    irq_glob_en = 1'b0;

    // R5 R6: arm under interrupt enable, clear by erase pulse
    do_reset();
    irq_glob_en = 1'b1;
    step(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R5 arm", {7'd0, erase_arm}, 8'h01);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R6 clear", {7'd0, erase_arm}, 8'h00);
    step(1'b1, 8'h02, 1'b0, 1'b0);
    step(1'b1, 8'h02, 1'b0, 1'b1);
    chk("R6 write loses", {7'd0, erase_arm}, 8'h00);
    irq_glob_en = 1'b0;

    // R7 R10: lock stays set; only reset clears
    ext_rd_req = 1'b1;
    step(1'b1, 8'h40, 1'b0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R7 sticky", {7'd0, sec_lock}, 8'h01);
    chk("R10 blocked", {7'd0, ext_rd_grant}, 8'h00);
    do_reset(); #1;
    chk("R7 reset", {7'd0, sec_lock}, 8'h00);
    chk("R10 pass", {7'd0, ext_rd_grant}, 8'h01);

    // R8: status bit follows input without a clock
    @(negedge clk); preboot_active = 1'b1; #0.5;
    chk("R8 high", sfr_rdata, 8'h80);
    preboot_active = 1'b0; #0.5;
    chk("R8 low", sfr_rdata, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule